// File: doc/BRIEF.md
# Inactivity Power-Down Timer

This block counts the time that passes without any comparator activity. Once that time reaches a programmed limit, it raises a power-down flag. Time arrives as a coarse base tick. A prescaler groups `TICKS_PER_UNIT` base ticks into one timeout unit, and each unit stands for four hours of real time. The timeout is a 6-bit unit count held in an 8-bit read/write configuration register, so code 6 means 24 hours and the largest code, 63, means about 10.5 days. A code of zero turns the automatic power-down off.

Any comparator strobe restarts the elapsed-time measurement. Writing the register restarts it as well. Once the flag is set it stays set until the serial-interface side sends a wake request, or until reset. Neither the time base nor the power gating is part of this block. The default of one base tick per unit keeps simulation short.

Top module: `pdn_inactivity_timer`

## Requirements
- R1: After reset the configuration readback is 0x40 and the power-down flag is low; the readback always shows the stored register.
- R2: A write stores write data bits [5:0] as the timeout code; readback bit 7 is always 0 and bit 6 is always 1, whatever was written there.
- R3: With a nonzero code T, the power-down flag rises at the clock edge that samples the (T x TICKS_PER_UNIT)-th base tick counted since the last restart. A base tick is any cycle with `tick_i` high.
- R4: With code 0 the flag never rises, however many ticks arrive.
- R5: A high bit on any comparator activity input restarts the elapsed count from zero. If it coincides with the tick that would complete the timeout, the activity wins and the flag stays low.
- R6: Once set, the flag stays high through ticks, comparator activity and register writes.
- R7: A wake request clears the flag at the next edge and restarts the elapsed count. If a wake request coincides with a completing tick, the flag stays low.
- R8: A register write restarts the elapsed count, even when it writes the same code again.
- R9: Code 63 is honoured without wrap: the flag rises after exactly 63 x TICKS_PER_UNIT ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration register write strobe |
| cfg_wdata | input | 8 | Configuration write data |
| tick_i | input | 1 | Coarse time-base tick, one count per high cycle |
| cmp_act_i | input | NUM_CMP | Comparator activity strobes |
| wake_i | input | 1 | Wake request from the serial interface |
| pwr_down_o | output | 1 | Power-down flag |
| cfg_rdata_o | output | 8 | Configuration register readback |

## Verification
The hardest situations to reach are the collisions on the exact cycle whose tick would complete the timeout: comparator activity arriving in that cycle, and a wake request arriving in that cycle. The stimulus counts ticks up to one short of the limit. It then drives the final tick together with the competing strobe in the same cycle, and counts a full period again to show that the restart really began from zero. The largest code is reached the same way, with a long run of ticks that ends one short of the limit and is then completed.

// File: rtl/pdt_pkg.sv
package pdt_pkg;
  localparam int REG_W = 8;
  localparam int TO_W  = 6;
  localparam logic [REG_W-1:0] REG_RST = 8'h40;

  // Force the fixed bits: bit 7 low, bit 6 high.
  function automatic logic [REG_W-1:0] pack_cfg(input logic [REG_W-1:0] w);
    return {2'b01, w[TO_W-1:0]};
  endfunction

  function automatic logic [TO_W-1:0] cfg_timeout(input logic [REG_W-1:0] r);
    return r[TO_W-1:0];
  endfunction

  // True when one more unit completes a nonzero timeout.
  function automatic logic units_reached(input logic [TO_W-1:0] done,
                                         input logic [TO_W-1:0] lim);
    return (lim != '0) && (({1'b0, done} + 1'b1) == {1'b0, lim});
  endfunction
endpackage

// File: rtl/pdt_cfg_reg.sv
module pdt_cfg_reg
  import pdt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] q_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q_o <= REG_RST;
    else if (we_i) q_o <= pack_cfg(wdata_i);
  end
endmodule

// File: rtl/pdt_prescaler.sv
module pdt_prescaler #(
  parameter int TICKS_PER_UNIT = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic tick_i,
  output logic unit_o
);
  localparam int PW = (TICKS_PER_UNIT > 1) ? $clog2(TICKS_PER_UNIT) : 1;
  localparam logic [PW-1:0] LAST = PW'(TICKS_PER_UNIT - 1);

  logic [PW-1:0] cnt_q;
  logic          at_last;

  assign at_last = (cnt_q == LAST);
  assign unit_o  = tick_i && at_last && !clr_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (tick_i) cnt_q <= at_last ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/pdt_elapsed.sv
module pdt_elapsed
  import pdt_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr_i,
  input  logic            unit_i,
  input  logic [TO_W-1:0] limit_i,
  output logic [TO_W-1:0] elapsed_o,
  output logic            expire_o
);
  logic [TO_W-1:0] cnt_q;

  assign elapsed_o = cnt_q;
  assign expire_o  = unit_i && units_reached(cnt_q, limit_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (unit_i) cnt_q <= expire_o ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/pdn_inactivity_timer.sv
module pdn_inactivity_timer
  import pdt_pkg::*;
#(
  parameter int TICKS_PER_UNIT = 1,
  parameter int NUM_CMP        = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [7:0]         cfg_wdata,
  input  logic               tick_i,
  input  logic [NUM_CMP-1:0] cmp_act_i,
  input  logic               wake_i,
  output logic               pwr_down_o,
  output logic [7:0]         cfg_rdata_o
);
  logic [REG_W-1:0] cfg_q;
  logic [TO_W-1:0]  limit_w;
  logic [TO_W-1:0]  elapsed_w;
  logic             act_any_w;
  logic             clear_w;
  logic             unit_w;
  logic             expire_w;
  logic             pd_q;

  assign act_any_w = |cmp_act_i;
  assign limit_w   = cfg_timeout(cfg_q);
  // Any restart source, plus holding still while disabled or powered down.
  assign clear_w   = act_any_w || cfg_we || wake_i || pd_q || (limit_w == '0);

  pdt_cfg_reg u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .we_i    (cfg_we),
    .wdata_i (cfg_wdata),
    .q_o     (cfg_q)
  );

  pdt_prescaler #(.TICKS_PER_UNIT(TICKS_PER_UNIT)) u_pre (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (clear_w),
    .tick_i (tick_i),
    .unit_o (unit_w)
  );

  pdt_elapsed u_elp (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_i     (clear_w),
    .unit_i    (unit_w),
    .limit_i   (limit_w),
    .elapsed_o (elapsed_w),
    .expire_o  (expire_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pd_q <= 1'b0;
    else if (wake_i)   pd_q <= 1'b0;
    else if (expire_w) pd_q <= 1'b1;
  end

  assign pwr_down_o  = pd_q;
  assign cfg_rdata_o = cfg_q;
endmodule

// File: rtl/pdt_checker.sv
module pdt_checker #(
  parameter int NUM_CMP = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cfg_we,
  input logic [NUM_CMP-1:0] cmp_act_i,
  input logic               wake_i,
  input logic               pwr_down_o,
  input logic [7:0]         cfg_rdata_o,
  input logic               expire_w,
  input logic [5:0]         elapsed_w
);
  AST_FIXED_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata_o[7:6] == 2'b01); // R2
  AST_RISE_ON_EXPIRY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwr_down_o) |-> $past(expire_w)); // R3
  AST_ZERO_DISABLES: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rdata_o[5:0] == 6'd0 && !pwr_down_o) |=> !pwr_down_o); // R4
  AST_ACTIVITY_HOLDS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    ((|cmp_act_i) && !pwr_down_o) |=> !pwr_down_o); // R5
  AST_PD_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_down_o && !wake_i) |=> pwr_down_o); // R6
  AST_WAKE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    wake_i |=> (!pwr_down_o && elapsed_w == 6'd0)); // R7
  AST_WRITE_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> elapsed_w == 6'd0); // R8
endmodule

bind pdn_inactivity_timer pdt_checker #(.NUM_CMP(NUM_CMP)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .cfg_we      (cfg_we),
  .cmp_act_i   (cmp_act_i),
  .wake_i      (wake_i),
  .pwr_down_o  (pwr_down_o),
  .cfg_rdata_o (cfg_rdata_o),
  .expire_w    (expire_w),
  .elapsed_w   (elapsed_w)
);

// File: tb/pdn_inactivity_timer_tb_top.sv
`timescale 1ns/1ps
module pdn_inactivity_timer_tb_top;
  localparam int TPU  = 2;
  localparam int NCMP = 2;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            cfg_we = 1'b0;
  logic [7:0]      cfg_wdata = 8'h00;
  logic            tick_i = 1'b0;
  logic [NCMP-1:0] cmp_act_i = '0;
  logic            wake_i = 1'b0;
  logic            pwr_down_o;
  logic [7:0]      cfg_rdata_o;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pdn_inactivity_timer #(.TICKS_PER_UNIT(TPU), .NUM_CMP(NCMP)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .tick_i(tick_i), .cmp_act_i(cmp_act_i), .wake_i(wake_i),
    .pwr_down_o(pwr_down_o), .cfg_rdata_o(cfg_rdata_o)
  );

  // Behavioural reference: register value, ticks seen in the current unit,
  // whole units seen, and the power-down state.
  int m_reg = 'h40;
  int m_sub = 0;
  int m_units = 0;
  bit m_pd = 0;

  always @(posedge clk) begin
    int lim;
    bit restart;
    bit finish_unit;
    if (!rst_n) begin
      m_reg = 'h40; m_sub = 0; m_units = 0; m_pd = 0;
    end else begin
      lim = m_reg % 64;
      restart = wake_i || cfg_we || (cmp_act_i != 0) || m_pd || (lim == 0);
      finish_unit = tick_i && (m_sub + 1 == TPU);
      if (wake_i) m_pd = 0;
      else if (!restart && finish_unit && (m_units + 1 == lim)) m_pd = 1;
      if (restart) begin
        m_sub = 0; m_units = 0;
      end else if (tick_i) begin
        if (finish_unit) begin
          m_sub = 0;
          m_units = (m_units + 1 == lim) ? 0 : m_units + 1;
        end else m_sub = m_sub + 1;
      end
      if (cfg_we) m_reg = 64 + (cfg_wdata % 64);
    end
  end

  // Per-cycle comparison against the model (R1 R3 R6 R7).
  always @(negedge clk) begin
    cycles++;
    if (rst_n && !done) begin
      total++;
      if (pwr_down_o !== m_pd || cfg_rdata_o !== 8'(m_reg)) begin
        bad++;
        $display("FAIL R1 R3 model: pd=%0b rd=%02h expected pd=%0b rd=%02h",
                 pwr_down_o, cfg_rdata_o, m_pd, m_reg);
      end
    end
    if (cycles > 200000 && !done) begin
      total++; bad++;
      $display("FAIL watchdog: cycles=%0d expected finish", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic expect_pd(input bit exp, input string tag);
    total++;
    if (pwr_down_o !== exp) begin
      bad++;
      $display("FAIL %s: pd=%0b expected %0b", tag, pwr_down_o, exp);
    end
  endtask

  task automatic expect_rd(input logic [7:0] exp, input string tag);
    total++;
    if (cfg_rdata_o !== exp) begin
      bad++;
      $display("FAIL %s: rdata=%02h expected %02h", tag, cfg_rdata_o, exp);
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick_i = 1'b1;
      @(negedge clk) tick_i = 1'b0;
    end
  endtask

  task automatic wr(input logic [7:0] v);
    @(negedge clk) begin cfg_we = 1'b1; cfg_wdata = v; end
    @(negedge clk) cfg_we = 1'b0;
  endtask

  task automatic wake();
    @(negedge clk) wake_i = 1'b1;
    @(negedge clk) wake_i = 1'b0;
  endtask

  task automatic act(input logic [NCMP-1:0] v);
    @(negedge clk) cmp_act_i = v;
    @(negedge clk) cmp_act_i = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    expect_rd(8'h40, "R1 reset value");
    expect_pd(1'b0, "R1 reset flag");

    wr(8'hC2); expect_rd(8'h42, "R2 bit7 forced low");
    wr(8'hBF); expect_rd(8'h7F, "R2 bit6 forced high");
    wr(8'h02); expect_rd(8'h42, "R2 code 2");

    ticks(3);  expect_pd(1'b0, "R3 one tick short");
    ticks(1);  expect_pd(1'b1, "R3 exact expiry");

    ticks(5); act(2'b01); wr(8'h05);
    expect_pd(1'b1, "R6 sticky after ticks, activity, write");
    expect_rd(8'h45, "R6 write while down");

    wake(); expect_pd(1'b0, "R7 wake clears");
    ticks(9); act(2'b10); ticks(9);
    expect_pd(1'b0, "R5 activity restarts count");
    ticks(1); expect_pd(1'b1, "R5 full period after activity");

    wake(); ticks(9);
    @(negedge clk) begin tick_i = 1'b1; wake_i = 1'b1; end
    @(negedge clk) begin tick_i = 1'b0; wake_i = 1'b0; end
    expect_pd(1'b0, "R7 wake beats final tick");
    ticks(9); expect_pd(1'b0, "R7 restart from zero");
    ticks(1); expect_pd(1'b1, "R7 full period after wake");

    wake(); ticks(9);
    @(negedge clk) begin tick_i = 1'b1; cmp_act_i = 2'b01; end
    @(negedge clk) begin tick_i = 1'b0; cmp_act_i = '0; end
    expect_pd(1'b0, "R5 activity beats final tick");
    ticks(9); expect_pd(1'b0, "R5 restart from zero");
    ticks(1); expect_pd(1'b1, "R5 expiry after collision");

    wake(); ticks(8); wr(8'h05); ticks(9);
    expect_pd(1'b0, "R8 same-code write restarts");
    ticks(1); expect_pd(1'b1, "R8 expiry after write");

    wake(); wr(8'h00); ticks(200);
    expect_pd(1'b0, "R4 code zero disables");

    wr(8'h3F); expect_rd(8'h7F, "R9 max code readback");
    ticks(125); expect_pd(1'b0, "R9 one tick short of max");
    ticks(1);   expect_pd(1'b1, "R9 max code expiry");

    repeat (2) @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule